// File: doc/BRIEF.md
# Oscillator Capacitor-Bank Calibration Sequencer

This block chooses the 9-bit capacitor-bank code that places a local oscillator inside the range where its PLL can lock. A host raises `cal_en` to start a run. The sequencer first performs a successive-approximation search over the code, most significant bit first. At each trial it waits one programmable step period and then reads a three-zone charge-pump voltage status to decide whether the trial bit stays set.

Two optional passes follow the search. A correction pass walks the code by one unit per correction period until the charge-pump voltage lies in its middle zone. A fine-adjust pass applies at most one further unit step. The sequencer then waits a programmable settling time and samples a built-in lock detector. That detector counts consecutive matching phase comparisons.

The oscillator receives either the calibrated code or a code written by the host, chosen by a select input. Two sticky error flags report failures: the correction pass running into either end of the code range, or no lock at the final check.

States and transitions:

- `ST_IDLE` goes to `ST_SAR_WAIT` when `cal_en` rises.
- `ST_SAR_WAIT` goes to `ST_SAR_DEC` when the step timer expires.
- `ST_SAR_DEC` either returns to `ST_SAR_WAIT` for the next lower bit, or, after bit 0, leaves the search. The exit goes to `ST_COR_WAIT` if correction is enabled, otherwise to `ST_FINE_WAIT` if fine adjust is enabled, otherwise to `ST_SETTLE`.
- `ST_COR_WAIT` goes to `ST_COR_DEC` when its timer expires.
- `ST_COR_DEC` either steps the code and returns to `ST_COR_WAIT`, or ends the pass when the status is in range (into `ST_FINE_WAIT` or `ST_SETTLE`), or raises the range error and goes to `ST_SETTLE`.
- `ST_FINE_WAIT` goes to `ST_FINE_DEC` when its timer expires.
- `ST_FINE_DEC` goes to `ST_SETTLE`.
- `ST_SETTLE` goes to `ST_CHECK` when the settle timer expires.
- `ST_CHECK` returns to `ST_IDLE`.

Top module: `vco_cal_seq`

## Requirements
- R1: After reset `busy`, `err_corr`, `err_lock` and `cal_code` are 0.
- R2: The search starts from code 256. At the end of each step period, status 3 clears the trial bit and any other status keeps it; the next lower bit is then set as the new trial. After bit 0 the code equals the target of a monotonic oscillator.
- R3: Each search step lasts `10 << step_sel` microseconds (`US_CYCLES` clock cycles per microsecond) plus one decision cycle. Nine steps are taken.
- R4: With `corr_en` = 1, after each period of `200 << corr_sel` microseconds the following applies. Status 0 adds 1 to the code and status 3 subtracts 1. Status 1 or 2 ends the pass.
- R5: If the correction pass must step past code 0 or 511, `err_corr` is set, the code is left unchanged, and the sequence proceeds directly to the settling wait.
- R6: With `fine_en` = 1, one extra period of the correction length is spent. After it, status 0 adds 1 and status 3 subtracts 1, once only.
- R7: The final settling wait lasts `200 << wait_sel` microseconds. After it, `err_lock` is set if `locked` is 0.
- R8: `locked` is 1 once the most recent 3 (`lock6` = 0) or 6 (`lock6` = 1) strobes on `cmp_stb` all had `cmp_ok` = 1. A strobe with `cmp_ok` = 0 clears the run.
- R9: `bank_code` equals `cal_code` when `use_cal` = 1 and `host_code` when `use_cal` = 0.
- R10: A run starts only on a rising edge of `cal_en` while idle, and `busy` is high from the next cycle until the run ends. Edges of `cal_en` during a run do not change the run's result or its length.
- R11: `err_clr` clears both error flags. The flags otherwise hold until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_en | input | 1 | Calibration request; a rising edge starts a run |
| corr_en | input | 1 | Enable the correction pass |
| fine_en | input | 1 | Enable the fine-adjust step |
| step_sel | input | 2 | Search step period select (10/20/40/80 us) |
| corr_sel | input | 2 | Correction period select (200/400/800/1600 us) |
| wait_sel | input | 2 | Settling wait select (200/400/800/1600 us) |
| cp_level | input | 2 | Charge-pump voltage status: 0 low, 1 middle, 3 high |
| cmp_stb | input | 1 | One pulse per phase comparison |
| cmp_ok | input | 1 | Comparison matched, valid with `cmp_stb` |
| lock6 | input | 1 | Lock needs 6 (1) or 3 (0) matching comparisons |
| use_cal | input | 1 | Bank code source: 1 calibrated, 0 host |
| host_code | input | 9 | Host-written bank code |
| err_clr | input | 1 | Clear both error flags |
| busy | output | 1 | Calibration run in progress |
| locked | output | 1 | Lock detector state |
| cal_code | output | 9 | Calibrated bank code |
| bank_code | output | 9 | Code applied to the oscillator |
| err_corr | output | 1 | Correction pass reached an end of the code range |
| err_lock | output | 1 | No lock after the settling wait |

## Verification
The hardest situation to reach from the ports is a correction pass that actually moves the code. A static oscillator model leaves the search result already in range. The bench therefore models the oscillator as a target code compared against `cal_code`, and moves that target a few units after the search has surely finished but before the first correction period expires. The correction walk and the single-unit fine step are then both observable. The range-error path is reached by holding the status pinned at 0 or 3, which drives the search to 511 or 0.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SAR_WAIT,
        ST_SAR_DEC,
        ST_COR_WAIT,
        ST_COR_DEC,
        ST_FINE_WAIT,
        ST_FINE_DEC,
        ST_SETTLE,
        ST_CHECK
    } cal_state_t;

    localparam logic [1:0] CP_LOW  = 2'd0;
    localparam logic [1:0] CP_MID  = 2'd1;
    localparam logic [1:0] CP_HIGH = 2'd3;

    localparam int unsigned STEP_BASE_US = 10;
    localparam int unsigned CORR_BASE_US = 200;
    localparam int unsigned WAIT_BASE_US = 200;

    function automatic int unsigned scaled_len(input int unsigned base_us,
                                               input logic [1:0]  sel,
                                               input int unsigned us_cyc);
        return (base_us * us_cyc) << sel;
    endfunction

endpackage

// File: rtl/cal_timer.sv
module cal_timer #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
    parameter int unsigned SHORT_RUN = 3,
    parameter int unsigned LONG_RUN  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic ok,
    input  logic need_long,
    output logic locked
);
    localparam int unsigned CW = $clog2(LONG_RUN + 1);
    localparam logic [CW-1:0] SAT   = CW'(LONG_RUN);
    localparam logic [CW-1:0] SHORT = CW'(SHORT_RUN);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (stb) begin
            if (!ok) begin
                run <= '0;
            end else if (run != SAT) begin
                run <= run + 1'b1;
            end
        end
    end

    assign locked = need_long ? (run >= SAT) : (run >= SHORT);
endmodule

// File: rtl/bank_sel.sv
module bank_sel #(
    parameter int unsigned W = 9
) (
    input  logic         use_cal,
    input  logic [W-1:0] cal_val,
    input  logic [W-1:0] host_val,
    output logic [W-1:0] out_val
);
    assign out_val = use_cal ? cal_val : host_val;
endmodule

// File: rtl/vco_cal_seq.sv
module vco_cal_seq
    import vcs_pkg::*;
#(
    parameter int unsigned CODE_W    = 9,
    parameter int unsigned US_CYCLES = 1,
    parameter int unsigned LOCK_A    = 3,
    parameter int unsigned LOCK_B    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_en,
    input  logic              corr_en,
    input  logic              fine_en,
    input  logic [1:0]        step_sel,
    input  logic [1:0]        corr_sel,
    input  logic [1:0]        wait_sel,
    input  logic [1:0]        cp_level,
    input  logic              cmp_stb,
    input  logic              cmp_ok,
    input  logic              lock6,
    input  logic              use_cal,
    input  logic [CODE_W-1:0] host_code,
    input  logic              err_clr,
    output logic              busy,
    output logic              locked,
    output logic [CODE_W-1:0] cal_code,
    output logic [CODE_W-1:0] bank_code,
    output logic              err_corr,
    output logic              err_lock
);
    localparam int unsigned MAX_LEN = 1600 * US_CYCLES;
    localparam int unsigned TMR_W   = $clog2(MAX_LEN + 1);
    localparam int unsigned BIT_W   = $clog2(CODE_W);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

    cal_state_t st, st_n;

    logic [CODE_W-1:0] code_q, code_n;
    logic [BIT_W-1:0]  bit_q, bit_n;
    logic              cal_en_q;
    logic              start;
    logic              t_load, t_exp;
    logic [TMR_W-1:0]  t_len;
    logic [TMR_W-1:0]  step_len, corr_len, wait_len;
    logic              ec_set, el_set;

    assign step_len = TMR_W'(scaled_len(STEP_BASE_US, step_sel, US_CYCLES));
    assign corr_len = TMR_W'(scaled_len(CORR_BASE_US, corr_sel, US_CYCLES));
    assign wait_len = TMR_W'(scaled_len(WAIT_BASE_US, wait_sel, US_CYCLES));

    assign start = cal_en && !cal_en_q;

    cal_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .len     (t_len),
        .expired (t_exp)
    );

    lock_watch #(.SHORT_RUN(LOCK_A), .LONG_RUN(LOCK_B)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (cmp_stb),
        .ok        (cmp_ok),
        .need_long (lock6),
        .locked    (locked)
    );

    bank_sel #(.W(CODE_W)) u_mux (
        .use_cal  (use_cal),
        .cal_val  (code_q),
        .host_val (host_code),
        .out_val  (bank_code)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // Next state and datapath controls
    always_comb begin
        st_n   = st;
        code_n = code_q;
        bit_n  = bit_q;
        t_load = 1'b0;
        t_len  = step_len;
        ec_set = 1'b0;
        el_set = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    code_n = CODE_MID;
                    bit_n  = BIT_W'(CODE_W - 1);
                    t_load = 1'b1;
                    t_len  = step_len;
                    st_n   = ST_SAR_WAIT;
                end
            end
            ST_SAR_WAIT: begin
                if (t_exp) st_n = ST_SAR_DEC;
            end
            ST_SAR_DEC: begin
                if (cp_level == CP_HIGH) code_n[bit_q] = 1'b0;
                if (bit_q != '0) begin
                    code_n[bit_q - 1'b1] = 1'b1;
                    bit_n  = bit_q - 1'b1;
                    t_load = 1'b1;
                    t_len  = step_len;
                    st_n   = ST_SAR_WAIT;
                end else if (corr_en) begin
                    t_load = 1'b1;
                    t_len  = corr_len;
                    st_n   = ST_COR_WAIT;
                end else if (fine_en) begin
                    t_load = 1'b1;
                    t_len  = corr_len;
                    st_n   = ST_FINE_WAIT;
                end else begin
                    t_load = 1'b1;
                    t_len  = wait_len;
                    st_n   = ST_SETTLE;
                end
            end
            ST_COR_WAIT: begin
                if (t_exp) st_n = ST_COR_DEC;
            end
            ST_COR_DEC: begin
                if (cp_level == CP_LOW || cp_level == CP_HIGH) begin
                    if ((cp_level == CP_LOW  && code_q == CODE_MAX) ||
                        (cp_level == CP_HIGH && code_q == '0)) begin
                        ec_set = 1'b1;
                        t_load = 1'b1;
                        t_len  = wait_len;
                        st_n   = ST_SETTLE;
                    end else begin
                        code_n = (cp_level == CP_LOW) ? code_q + 1'b1 : code_q - 1'b1;
                        t_load = 1'b1;
                        t_len  = corr_len;
                        st_n   = ST_COR_WAIT;
                    end
                end else if (fine_en) begin
                    t_load = 1'b1;
                    t_len  = corr_len;
                    st_n   = ST_FINE_WAIT;
                end else begin
                    t_load = 1'b1;
                    t_len  = wait_len;
                    st_n   = ST_SETTLE;
                end
            end
            ST_FINE_WAIT: begin
                if (t_exp) st_n = ST_FINE_DEC;
            end
            ST_FINE_DEC: begin
                if (cp_level == CP_LOW && code_q != CODE_MAX) begin
                    code_n = code_q + 1'b1;
                end else if (cp_level == CP_HIGH && code_q != '0) begin
                    code_n = code_q - 1'b1;
                end
                t_load = 1'b1;
                t_len  = wait_len;
                st_n   = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (t_exp) st_n = ST_CHECK;
            end
            ST_CHECK: begin
                if (!locked) el_set = 1'b1;
                st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Datapath and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            bit_q    <= '0;
            cal_en_q <= 1'b0;
            err_corr <= 1'b0;
            err_lock <= 1'b0;
        end else begin
            code_q   <= code_n;
            bit_q    <= bit_n;
            cal_en_q <= cal_en;
            if (err_clr) begin
                err_corr <= 1'b0;
                err_lock <= 1'b0;
            end else begin
                if (ec_set) err_corr <= 1'b1;
                if (el_set) err_lock <= 1'b1;
            end
        end
    end

    assign cal_code = code_q;
    assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
    parameter int unsigned CODE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_en,
    input logic              busy,
    input logic [CODE_W-1:0] cal_code,
    input logic              err_corr,
    input logic              err_lock,
    input logic              err_clr,
    input logic              cmp_stb,
    input logic              cmp_ok,
    input logic              locked
);
    assert_code_frozen_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cal_en && !$past(cal_en))) |=> $stable(cal_code));

    assert_corr_err_at_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_corr) |-> (cal_code == '0 || cal_code == '1));

    assert_err_only_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_corr) || $rose(err_lock)) |-> $past(busy));

    assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (!err_corr && !err_lock));

    assert_lock_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmp_stb && cmp_ok) || $past(!cmp_stb));

    assert_lock_drop_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && !cmp_ok) |=> !locked);
endmodule

bind vco_cal_seq vcs_checker #(.CODE_W(CODE_W)) u_vcs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_en   (cal_en),
    .busy     (busy),
    .cal_code (cal_code),
    .err_corr (err_corr),
    .err_lock (err_lock),
    .err_clr  (err_clr),
    .cmp_stb  (cmp_stb),
    .cmp_ok   (cmp_ok),
    .locked   (locked)
);

// File: tb/sim_vco_cal_seq.sv
`timescale 1ns/1ps
module sim_vco_cal_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_en = 1'b0, corr_en = 1'b0, fine_en = 1'b0;
    logic [1:0] step_sel = 2'd0, corr_sel = 2'd0, wait_sel = 2'd0;
    logic [1:0] cp_level;
    logic       cmp_stb = 1'b0, cmp_ok = 1'b0, lock6 = 1'b0;
    logic       use_cal = 1'b0;
    logic [8:0] host_code = 9'd77;
    logic       err_clr = 1'b0;
    logic       busy, locked, err_corr, err_lock;
    logic [8:0] cal_code, bank_code;

    int         checks = 0, fails = 0, cyc = 0;
    int         tgt = 300;
    logic       pin_mode = 1'b0;
    logic [1:0] pin_val = 2'd0;

    always #5 clk = ~clk;

    // Oscillator model: status from calibrated code versus target
    always_comb begin
        if (pin_mode) cp_level = pin_val;
        else if (int'(cal_code) < tgt) cp_level = 2'd0;
        else if (int'(cal_code) > tgt) cp_level = 2'd3;
        else cp_level = 2'd1;
    end

    vco_cal_seq u0 (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .corr_en(corr_en),
        .fine_en(fine_en), .step_sel(step_sel), .corr_sel(corr_sel),
        .wait_sel(wait_sel), .cp_level(cp_level), .cmp_stb(cmp_stb),
        .cmp_ok(cmp_ok), .lock6(lock6), .use_cal(use_cal),
        .host_code(host_code), .err_clr(err_clr), .busy(busy),
        .locked(locked), .cal_code(cal_code), .bank_code(bank_code),
        .err_corr(err_corr), .err_lock(err_lock)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobes(input int n, input logic ok);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cmp_stb = 1'b1; cmp_ok = ok;
            @(negedge clk); cmp_stb = 1'b0;
        end
    endtask

    task automatic clear_err;
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // Starts a run and returns the number of cycles busy stayed high
    task automatic run_cal(output int n);
        @(negedge clk); cal_en = 1'b1;
        @(negedge clk);
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk); n++;
        end
        cal_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(busy == 0, "R1 busy", busy, 0);
        check(err_corr == 0 && err_lock == 0, "R1 errors", {err_corr, err_lock}, 0);
        check(cal_code == 0, "R1 cal_code", cal_code, 0);
        check(bank_code == 77, "R9 host path", bank_code, 77);
    endtask

    task automatic t_search(input int t);
        int n;
        tgt = t; pin_mode = 0; corr_en = 0; fine_en = 0;
        run_cal(n);
        check(cal_code == 9'(t), "R2 search result", cal_code, t);
        check(err_corr == 0 && err_lock == 0, "R2 no error", {err_corr, err_lock}, 0);
    endtask

    task automatic t_mux;
        use_cal = 1; #1;
        check(bank_code == cal_code, "R9 calibrated path", bank_code, cal_code);
        use_cal = 0; host_code = 9'd400; #1;
        check(bank_code == 9'd400, "R9 host path", bank_code, 400);
    endtask

    task automatic t_step_time;
        int a, b;
        tgt = 123; step_sel = 0; run_cal(a);
        step_sel = 3; run_cal(b);
        check(b - a == 9 * 70, "R3 step period", b - a, 630);
        step_sel = 1; run_cal(b);
        check(b - a == 9 * 10, "R3 step period sel1", b - a, 90);
        step_sel = 0;
    endtask

    task automatic t_wait_time;
        int a, b;
        tgt = 50; wait_sel = 0; run_cal(a);
        wait_sel = 3; run_cal(b);
        check(b - a == 1400, "R7 settle wait", b - a, 1400);
        wait_sel = 0;
    endtask

    task automatic t_correct;
        int n;
        tgt = 300; corr_en = 1; fine_en = 0; pin_mode = 0;
        fork
            run_cal(n);
            begin repeat (150) @(negedge clk); tgt = 303; end
        join
        check(cal_code == 303, "R4 correction walk", cal_code, 303);
        check(err_corr == 0, "R4 no range error", err_corr, 0);
        corr_en = 0;
    endtask

    task automatic t_corr_edge;
        int n;
        corr_en = 1; pin_mode = 1; pin_val = 2'd0;
        run_cal(n);
        check(cal_code == 511, "R5 top code", cal_code, 511);
        check(err_corr == 1, "R5 flag at top", err_corr, 1);
        repeat (5) @(negedge clk);
        check(err_corr == 1, "R11 flag holds", err_corr, 1);
        clear_err;
        check(err_corr == 0, "R11 flag cleared", err_corr, 0);
        pin_val = 2'd3;
        run_cal(n);
        check(cal_code == 0, "R5 bottom code", cal_code, 0);
        check(err_corr == 1, "R5 flag at bottom", err_corr, 1);
        clear_err;
        pin_mode = 0; corr_en = 0;
    endtask

    task automatic t_fine;
        int n;
        tgt = 200; corr_en = 0; fine_en = 1;
        fork
            run_cal(n);
            begin repeat (150) @(negedge clk); tgt = 203; end
        join
        check(cal_code == 201, "R6 single fine step", cal_code, 201);
        fine_en = 0;
    endtask

    task automatic t_lock;
        int n;
        strobes(1, 0);
        check(locked == 0, "R8 miss clears", locked, 0);
        lock6 = 0; strobes(3, 1);
        check(locked == 1, "R8 three matches", locked, 1);
        lock6 = 1; #1;
        check(locked == 0, "R8 six needed", locked, 0);
        tgt = 90; run_cal(n);
        check(err_lock == 1, "R7 lock error", err_lock, 1);
        clear_err;
        strobes(3, 1);
        check(locked == 1, "R8 six matches", locked, 1);
        run_cal(n);
        check(err_lock == 0, "R7 locked no error", err_lock, 0);
    endtask

    task automatic t_retrigger;
        int a, b;
        tgt = 222; run_cal(a);
        @(negedge clk); cal_en = 1'b1;
        @(negedge clk);
        b = 0;
        fork
            while (busy && b < 20000) begin @(negedge clk); b++; end
            begin
                repeat (20) @(negedge clk); cal_en = 1'b0;
                repeat (5) @(negedge clk); cal_en = 1'b1;
            end
        join
        cal_en = 1'b0;
        @(negedge clk);
        check(b == a, "R10 retrigger ignored length", b, a);
        check(cal_code == 222, "R10 retrigger ignored code", cal_code, 222);
        check(busy == 0, "R10 idle after run", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        strobes(6, 1);
        t_search(300);
        t_mux;
        t_search(0);
        t_search(511);
        t_search(1);
        t_step_time;
        t_wait_time;
        t_correct;
        t_corr_edge;
        t_fine;
        t_lock;
        t_retrigger;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule